// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This block gathers the event and error pulses produced by the command and data engines of an SD/MMC host controller. It holds them as sticky status flags and turns them into a single interrupt request for the processor. Two masks act in turn. The capture mask decides whether an event pulse is recorded at all. The signalling mask then decides which recorded flags may raise the interrupt line.

Software reads and writes the three registers through a small word port. It clears flags by writing ones to the status word. Three combinational summary lines come from the recorded flags:
- any command-phase error;
- any data-phase error;
- the end of the command phase, by completion or by timeout.

Driver code uses the two error summaries to decide whether to reset only the command path or the data path as well.

Top module: `sdh_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, the status, capture-mask and signal-mask registers all read zero, and `irq_o`, `cmd_err_o`, `data_err_o` and `cmd_over_o` are low.
- R2: An event pulse on `ev_i[k]` while capture-mask bit k is set makes status bit k read one from the next clock edge. A write to the capture mask affects only events from the following cycle on.
- R3: An event whose capture-mask bit is clear is not recorded. This covers buffer read ready and buffer write ready, which start out masked. Event bit positions are: 0 command done, 1 transfer done, 2 buffer write ready, 3 buffer read ready, 4 card interrupt, 5 command timeout, 6 command CRC error, 7 command end-bit error, 8 command index error, 9 data timeout, 10 data CRC error, 11 data end-bit error, 12 DMA error.
- R4: A write to the status address clears exactly the bits written as one and leaves the other bits unchanged. A write of all ones clears every flag.
- R5: When an event pulse and a write-one-to-clear of the same bit land in one cycle, the bit stays set.
- R6: `irq_o` is a registered output. It is high in the cycle after some status bit with its signal-mask bit set exists, and low in the cycle after no such bit exists.
- R7: With the signal mask all zero, `irq_o` stays low while status bits are still recorded.
- R8: `cmd_err_o` is high exactly while any of status bits 5, 6, 7 or 8 is set.
- R9: `data_err_o` is high exactly while any of status bits 9, 10, 11 or 12 is set.
- R10: `cmd_over_o` is high exactly while status bit 0 or status bit 5 is set.
- R11: Register map: address 0 is status (write one to clear), address 1 is the capture mask, address 2 is the signal mask, and address 3 reads zero with writes ignored. `reg_rdata_o` is combinational from the addressed register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_i | input | 13 | One-cycle event pulses from the host engines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 13 | Register write data |
| reg_rdata_o | output | 13 | Read data of the addressed register |
| irq_o | output | 1 | Registered interrupt request |
| cmd_err_o | output | 1 | Any command-phase error flag set |
| data_err_o | output | 1 | Any data-phase error flag set |
| cmd_over_o | output | 1 | Command phase ended (done or timeout) |

## Verification
The bench applies an event and a clear of the same bit in one cycle. A design that gives the clear priority would lose that event, and the flag would read zero. It writes the capture mask in the same cycle as an event. A design that bypasses the new mask combinationally would record that event one cycle too early. It drives events with the signal mask at zero, and counts the exact cycle in which the interrupt rises and falls, so an unregistered or wrongly masked interrupt line shows a mismatch. It also walks each event bit through its summary outputs and writes to the unused address, which catches a swapped error group or an alias onto a live register.

// File: rtl/sdh_irq_pkg.sv
// Package: shared constants for the SD host interrupt status unit.
// Assumes: thirteen event sources at fixed bit positions; the error groups
// and the command-phase-end set are decoded by position.
package sdh_irq_pkg;

    localparam int NUM_EV = 13;

    localparam int EV_CMD_DONE = 0;
    localparam int EV_XFER_DONE = 1;
    localparam int EV_BUF_WR = 2;
    localparam int EV_BUF_RD = 3;
    localparam int EV_CARD = 4;
    localparam int EV_CMD_TOUT = 5;
    localparam int EV_CMD_CRC = 6;
    localparam int EV_CMD_END = 7;
    localparam int EV_CMD_IDX = 8;
    localparam int EV_DAT_TOUT = 9;
    localparam int EV_DAT_CRC = 10;
    localparam int EV_DAT_END = 11;
    localparam int EV_DMA = 12;

    localparam logic [NUM_EV-1:0] CMD_ERR_MASK =
        (NUM_EV'(1) << EV_CMD_TOUT) | (NUM_EV'(1) << EV_CMD_CRC) |
        (NUM_EV'(1) << EV_CMD_END) | (NUM_EV'(1) << EV_CMD_IDX);

    localparam logic [NUM_EV-1:0] DAT_ERR_MASK =
        (NUM_EV'(1) << EV_DAT_TOUT) | (NUM_EV'(1) << EV_DAT_CRC) |
        (NUM_EV'(1) << EV_DAT_END) | (NUM_EV'(1) << EV_DMA);

    localparam logic [NUM_EV-1:0] CMD_OVER_MASK =
        (NUM_EV'(1) << EV_CMD_DONE) | (NUM_EV'(1) << EV_CMD_TOUT);

    localparam int ADDR_STAT = 0;
    localparam int ADDR_CAPEN = 1;
    localparam int ADDR_SIGEN = 2;

endpackage

// File: rtl/sdh_irq_status.sv
// Module: sticky status flags, one flop per event source.
// Each flag sets when its event pulses while its capture-mask bit is set,
// and clears on a write-one-to-clear. A set in the same cycle wins over a clear.
// Assumes: clr_i is already decoded from the register port.
module sdh_irq_status #(
    parameter int NUM_EV = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev_i,
    input  logic [NUM_EV-1:0] capen_i,
    input  logic [NUM_EV-1:0] clr_i,
    output logic [NUM_EV-1:0] stat_o
);

    for (genvar k = 0; k < NUM_EV; k++) begin : g_flag
        logic set_k;
        assign set_k = ev_i[k] & capen_i[k];

        // Purpose: hold flag k, with set taking priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat_o[k] <= 1'b0;
            end else if (set_k) begin
                stat_o[k] <= 1'b1;
            end else if (clr_i[k]) begin
                stat_o[k] <= 1'b0;
            end
        end

        // R2
        ev_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_i[k] && capen_i[k]) |=> stat_o[k]);

        // R3
        no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!stat_o[k] && !(ev_i[k] && capen_i[k])) |=> !stat_o[k]);

        // R4
        w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !ev_i[k]) |=> !stat_o[k]);
    end

endmodule

// File: rtl/sdh_irq_regs.sv
// Module: register port holding the capture and signal masks.
// Decodes write-one-to-clear strobes for the status flags and muxes read data.
// Assumes: a single-cycle write strobe and combinational reads; any
// unmapped address reads zero and ignores writes.
module sdh_irq_regs
    import sdh_irq_pkg::*;
#(
    parameter int NUM_EV = 13,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NUM_EV-1:0] wdata_i,
    input  logic [NUM_EV-1:0] stat_i,
    output logic [NUM_EV-1:0] capen_o,
    output logic [NUM_EV-1:0] sigen_o,
    output logic [NUM_EV-1:0] clr_o,
    output logic [NUM_EV-1:0] rdata_o
);

    logic hit_stat, hit_capen, hit_sigen;

    assign hit_stat  = (addr_i == ADDR_W'(ADDR_STAT));
    assign hit_capen = (addr_i == ADDR_W'(ADDR_CAPEN));
    assign hit_sigen = (addr_i == ADDR_W'(ADDR_SIGEN));

    assign clr_o = (wr_i && hit_stat) ? wdata_i : '0;

    // Purpose: update the capture mask on a write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            capen_o <= '0;
        end else if (wr_i && hit_capen) begin
            capen_o <= wdata_i;
        end
    end

    // Purpose: update the signal mask on a write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sigen_o <= '0;
        end else if (wr_i && hit_sigen) begin
            sigen_o <= wdata_i;
        end
    end

    // Purpose: select read data for the addressed register.
    always_comb begin
        if (hit_stat) begin
            rdata_o = stat_i;
        end else if (hit_capen) begin
            rdata_o = capen_o;
        end else if (hit_sigen) begin
            rdata_o = sigen_o;
        end else begin
            rdata_o = '0;
        end
    end

    // R2
    capen_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && hit_capen) |=> (capen_o == $past(wdata_i)));

    // R11
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !hit_stat && !hit_capen && !hit_sigen) |=>
        ($stable(capen_o) && $stable(sigen_o)));

endmodule

// File: rtl/sdh_irq_signal.sv
// Module: interrupt request and summary outputs.
// The request is a registered OR of the flags that the signal mask allows.
// The summaries are combinational ORs of fixed flag groups.
// Assumes: group membership comes from the shared package masks.
module sdh_irq_signal
    import sdh_irq_pkg::*;
#(
    parameter int NUM_EV = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] stat_i,
    input  logic [NUM_EV-1:0] sigen_i,
    output logic              irq_o,
    output logic              cmd_err_o,
    output logic              data_err_o,
    output logic              cmd_over_o
);

    logic irq_d;
    assign irq_d = |(stat_i & sigen_i);

    // Purpose: register the masked interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= irq_d;
        end
    end

    assign cmd_err_o  = |(stat_i & CMD_ERR_MASK[NUM_EV-1:0]);
    assign data_err_o = |(stat_i & DAT_ERR_MASK[NUM_EV-1:0]);
    assign cmd_over_o = |(stat_i & CMD_OVER_MASK[NUM_EV-1:0]);

    // R6
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_i & sigen_i)) |=> irq_o);

    // R7
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sigen_i == '0) |=> !irq_o);

endmodule

// File: rtl/sdh_irq_unit.sv
// Module: top of the SD host interrupt status unit.
// Connects the register port, the sticky status flags and the signalling logic.
// Assumes: event inputs are one-cycle pulses synchronous to clk.
module sdh_irq_unit
    import sdh_irq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [NUM_EV-1:0] reg_wdata_i,
    output logic [NUM_EV-1:0] reg_rdata_o,
    output logic              irq_o,
    output logic              cmd_err_o,
    output logic              data_err_o,
    output logic              cmd_over_o
);

    logic [NUM_EV-1:0] stat, capen, sigen, clr;

    sdh_irq_regs #(.NUM_EV(NUM_EV), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .stat_i  (stat),
        .capen_o (capen),
        .sigen_o (sigen),
        .clr_o   (clr),
        .rdata_o (reg_rdata_o)
    );

    sdh_irq_status #(.NUM_EV(NUM_EV)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_i    (ev_i),
        .capen_i (capen),
        .clr_i   (clr),
        .stat_o  (stat)
    );

    sdh_irq_signal #(.NUM_EV(NUM_EV)) u_signal (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_i     (stat),
        .sigen_i    (sigen),
        .irq_o      (irq_o),
        .cmd_err_o  (cmd_err_o),
        .data_err_o (data_err_o),
        .cmd_over_o (cmd_over_o)
    );

    // R8
    cmd_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_err_o) |-> (|($past(ev_i) & $past(capen) & CMD_ERR_MASK)));

    // R9
    dat_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_err_o) |-> (|($past(ev_i) & $past(capen) & DAT_ERR_MASK)));

endmodule

// File: tb/sim_sdh_irq_unit.sv
// Bench: the driver task models each cycle and queues the expected outputs.
// A monitor pops one item after every clock edge and compares it.
module sim_sdh_irq_unit;

    localparam int PERIOD = 10;
    localparam int NE = 13;
    localparam logic [12:0] ALL  = 13'h1FFF;
    localparam logic [12:0] B_CC = 13'h0001, B_BWR = 13'h0004, B_BRR = 13'h0008;
    localparam logic [12:0] B_CTO = 13'h0020, B_CCRC = 13'h0040, B_CEND = 13'h0080;
    localparam logic [12:0] B_CIDX = 13'h0100, B_DTO = 13'h0200, B_DCRC = 13'h0400;
    localparam logic [12:0] B_DMA = 13'h1000;
    localparam logic [12:0] CE_M = 13'h01E0, DE_M = 13'h1E00, CO_M = 13'h0021;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NE-1:0] ev_i = '0;
    logic reg_wr_i = 1'b0;
    logic [1:0] reg_addr_i = '0;
    logic [NE-1:0] reg_wdata_i = '0;
    logic [NE-1:0] reg_rdata_o;
    logic irq_o, cmd_err_o, data_err_o, cmd_over_o;

    always #(PERIOD/2) clk = ~clk;

    sdh_irq_unit #(.ADDR_W(2)) u0 (
        .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .reg_wr_i(reg_wr_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .irq_o(irq_o), .cmd_err_o(cmd_err_o),
        .data_err_o(data_err_o), .cmd_over_o(cmd_over_o)
    );

    typedef struct {
        string req;
        logic [12:0] rd;
        logic irq, ce, de, co;
    } exp_t;

    exp_t q[$];
    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    logic [12:0] m_stat = '0, m_capen = '0, m_sigen = '0;

    task automatic chk(string req, string what, logic [12:0] act, logic [12:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the expected outputs.
    task automatic cyc(logic [12:0] ev, logic wr, logic [1:0] addr,
                       logic [12:0] wd, string req);
        logic [12:0] clr, n_stat, n_capen, n_sigen;
        exp_t e;
        @(negedge clk);
        ev_i = ev; reg_wr_i = wr; reg_addr_i = addr; reg_wdata_i = wd;
        clr = (wr && addr == 2'd0) ? wd : '0;
        n_stat = (m_stat & ~clr) | (ev & m_capen);
        n_capen = (wr && addr == 2'd1) ? wd : m_capen;
        n_sigen = (wr && addr == 2'd2) ? wd : m_sigen;
        e.req = req;
        e.irq = |(m_stat & m_sigen);
        e.ce = |(n_stat & CE_M);
        e.de = |(n_stat & DE_M);
        e.co = |(n_stat & CO_M);
        case (addr)
            2'd0: e.rd = n_stat;
            2'd1: e.rd = n_capen;
            2'd2: e.rd = n_sigen;
            default: e.rd = '0;
        endcase
        m_stat = n_stat; m_capen = n_capen; m_sigen = n_sigen;
        q.push_back(e);
    endtask

    // Monitor: compare outputs a quarter period after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #(PERIOD/4);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.req, "rdata", reg_rdata_o, e.rd);
                chk(e.req, "irq", 13'(irq_o), 13'(e.irq));
                chk(e.req, "cmd_err", 13'(cmd_err_o), 13'(e.ce));
                chk(e.req, "data_err", 13'(data_err_o), 13'(e.de));
                chk(e.req, "cmd_over", 13'(cmd_over_o), 13'(e.co));
            end
        end
    end

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values of all three registers and the outputs
        cyc('0, 0, 2'd0, '0, "R1");
        cyc('0, 0, 2'd1, '0, "R1");
        cyc('0, 0, 2'd2, '0, "R1");
        // R3 nothing recorded while the capture mask is zero
        cyc(ALL, 0, 2'd0, '0, "R3");
        // R2 a mask write in the same cycle as an event does not capture it
        cyc(B_CC, 1, 2'd1, ALL & ~(B_BRR | B_BWR), "R2");
        cyc('0, 0, 2'd0, '0, "R2");
        // R3 buffer ready events stay masked
        cyc(B_BRR | B_BWR, 0, 2'd0, '0, "R3");
        // R7 a flag is recorded but no interrupt with a zero signal mask
        cyc(B_CC, 0, 2'd0, '0, "R7");
        cyc('0, 0, 2'd0, '0, "R7");
        // R6 the interrupt rises one cycle after the signal mask allows it
        cyc('0, 1, 2'd2, B_CC, "R6");
        cyc('0, 0, 2'd2, '0, "R6");
        cyc('0, 1, 2'd0, B_CC, "R4");
        cyc('0, 0, 2'd0, '0, "R6");
        cyc('0, 0, 2'd0, '0, "R6");
        // R5 a set and a clear in the same cycle leave the flag set
        cyc(B_CC, 1, 2'd0, B_CC, "R5");
        cyc('0, 0, 2'd0, '0, "R5");
        cyc('0, 1, 2'd0, ALL, "R4");
        // R8 command error group
        cyc(B_CCRC, 0, 2'd0, '0, "R8");
        cyc(B_CIDX | B_CEND, 0, 2'd0, '0, "R8");
        cyc('0, 1, 2'd0, ALL, "R4");
        // R9 data error group, then a partial clear
        cyc(B_DMA, 0, 2'd0, '0, "R9");
        cyc(B_DCRC, 0, 2'd0, '0, "R9");
        cyc('0, 1, 2'd0, B_DMA, "R4");
        cyc('0, 1, 2'd0, ALL, "R4");
        // R10 the command phase ends by timeout or by completion
        cyc(B_CTO, 0, 2'd0, '0, "R10");
        cyc('0, 1, 2'd0, ALL, "R10");
        cyc(B_CC, 0, 2'd0, '0, "R10");
        // R11 the unmapped address reads zero and ignores writes
        cyc(B_DTO, 1, 2'd3, ALL, "R11");
        cyc('0, 0, 2'd1, '0, "R11");
        cyc('0, 0, 2'd2, '0, "R11");
        cyc('0, 1, 2'd0, ALL, "R4");
        // R2 walk every event bit, each with full signalling
        cyc('0, 1, 2'd2, ALL, "R2");
        for (int i = 0; i < NE; i++) begin
            cyc(13'(1) << i, 0, 2'd0, '0, "R2");
            cyc('0, 1, 2'd0, ALL, "R4");
        end
        // R2 enable buffer read ready, then capture it
        cyc('0, 1, 2'd1, ALL, "R2");
        cyc(B_BRR, 0, 2'd0, '0, "R2");
        // R7 clearing the signal mask drops the interrupt, status remains
        cyc('0, 1, 2'd2, '0, "R7");
        cyc(B_DTO, 0, 2'd0, '0, "R7");
        cyc('0, 0, 2'd0, '0, "R7");
        @(posedge clk);
        #(PERIOD/2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule